// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter with Power-of-Two Prescaler

This block is a 16-bit down-counter that produces a periodic interrupt. A small synchronous register port gives access to three halfword registers: a control word, a modulus, and the live count. The count advances at the system clock rate divided by two and then by a programmable power of two. When the count expires, a sticky flag is set. The counter then either restarts from the modulus or wraps to full scale and keeps running. A level interrupt is driven whenever the flag and its enable are both set.

Software can change the interrupt enable or acknowledge the flag without disturbing a running count. Any other change to the control word reprograms the timer and restarts it. An optional overwrite mode loads the count as soon as a new modulus is written. The debug and doze bits are stored and read back but have no effect.

Top module: `pit16_timer`

## Requirements
- R1: After reset the control word, modulus and count all read 0, the counter is stopped and `irq` is 0.
- R2: Addressing uses byte offsets, and bit 0 of the address must be 0 to select anything. Offset 0 is the control word, offset 2 is the modulus and offset 4 is the count. Any other offset reads 0. The control word reads back as: bit 0 enable, bit 1 reload, bit 2 flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 debug, bit 6 doze, bits 11:8 prescaler code, and 0 in all other bits. Reads have no side effects, and the data appears on `rdata` in the cycle after the read strobe.
- R3: The count moves down by one every 2^(code+1) clock cycles, and only while enable is 1. The divider is cleared on each reprogramming write. The first decrement happens 2^(code+1) cycles after that write.
- R4: With reload set, a tick that finds the count at 0 sets the flag and loads the modulus. The period is therefore modulus+1 ticks.
- R5: With reload clear, a tick that finds the count at 0 sets the flag and wraps the count to 0xFFFF.
- R6: Writing a control word with bit 2 at 1 clears the flag. Writing it with bit 2 at 0 leaves the flag unchanged.
- R7: `irq` is 1 exactly when both the interrupt enable bit and the flag are 1.
- R8: Any write to the modulus clears the flag.
- R9: If overwrite is set, a modulus write also loads the written value into the count at once. If overwrite is clear, the count is untouched and only the reload value changes.
- R10: A control write that differs from the stored control word only in bit 3 and/or bit 2 does not restart, reload or re-phase the counter.
- R11: Any other control write clears the divider. If the new enable is 1, it loads the count with the modulus (reload set) or with 0xFFFF (reload clear). If the new enable is 0, the count holds its value, and it keeps holding while the timer stays disabled.
- R12: Writes to the count offset change no register.
- R13: If an expiry and a flag-clear write fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| irq | output | 1 | Level interrupt, registered |

## Verification
Two events can land on the same clock edge: the counter expiring, which sets the flag, and a control write that acknowledges the flag. The bench uses a short modulus at the fastest divider. It counts the edges from the enabling write, so that the acknowledge write lands exactly on the expiry edge. It then expects `irq` and the read-back flag to stay at 1. A second acknowledge one cycle later, clear of any expiry, must drop the flag. The count read after that is checked to show the acknowledges left the counter's phase intact.

// File: rtl/pit16_pkg.sv
package pit16_pkg;
  // register selects (byte offset >> 1)
  localparam int REG_CTRL = 0;
  localparam int REG_MOD  = 1;
  localparam int REG_CNT  = 2;

  // control word bit positions
  localparam int B_EN      = 0;
  localparam int B_RLD     = 1;
  localparam int B_FLG     = 2;
  localparam int B_IE      = 3;
  localparam int B_OVW     = 4;
  localparam int B_DBG     = 5;
  localparam int B_DOZE    = 6;
  localparam int B_PRE_LSB = 8;
endpackage

// File: rtl/pit16_regs.sv
module pit16_regs
  import pit16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output logic              ctl_en,
  output logic              ctl_rld,
  output logic              ctl_ie,
  output logic              ctl_ovw,
  output logic [PRE_W-1:0]  ctl_pre,
  output logic              flag,
  output logic [CNT_W-1:0]  mod,
  output logic              restart,
  output logic              start,
  output logic [CNT_W-1:0]  start_val,
  output logic              mod_load,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 1;
  localparam logic [CNT_W-1:0] PRE_MASK = CNT_W'(((1 << PRE_W) - 1) << B_PRE_LSB);
  localparam logic [CNT_W-1:0] CFG_MASK =
    PRE_MASK | CNT_W'((1 << B_EN) | (1 << B_RLD) | (1 << B_OVW) | (1 << B_DBG) | (1 << B_DOZE));

  logic [SEL_W-1:0] sel;
  logic             aligned;
  logic             wr_ctl, wr_mod;
  logic             dbg_q, doze_q;
  logic [CNT_W-1:0] ctl_img;
  logic             cfg_change;
  logic             flag_clr, flag_n, ie_n;

  assign sel     = addr[ADDR_W-1:1];
  assign aligned = ~addr[0];
  assign wr_ctl  = wr_en && aligned && (sel == SEL_W'(REG_CTRL));
  assign wr_mod  = wr_en && aligned && (sel == SEL_W'(REG_MOD));

  always_comb begin
    ctl_img = '0;
    ctl_img[B_EN]   = ctl_en;
    ctl_img[B_RLD]  = ctl_rld;
    ctl_img[B_FLG]  = flag;
    ctl_img[B_IE]   = ctl_ie;
    ctl_img[B_OVW]  = ctl_ovw;
    ctl_img[B_DBG]  = dbg_q;
    ctl_img[B_DOZE] = doze_q;
    ctl_img[B_PRE_LSB +: PRE_W] = ctl_pre;
  end

  // only bits other than IE/flag-ack decide a reprogram
  assign cfg_change = (((ctl_img ^ wdata) & CFG_MASK) != '0);
  assign restart    = wr_ctl && cfg_change;
  assign start      = restart && wdata[B_EN];
  assign start_val  = wdata[B_RLD] ? mod : '1;
  assign mod_load   = wr_mod && ctl_ovw;

  // set beats clear
  assign flag_clr = (wr_ctl && wdata[B_FLG]) || wr_mod;
  assign flag_n   = expire || (flag && !flag_clr);
  assign ie_n     = wr_ctl ? wdata[B_IE] : ctl_ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en  <= 1'b0;
      ctl_rld <= 1'b0;
      ctl_ie  <= 1'b0;
      ctl_ovw <= 1'b0;
      dbg_q   <= 1'b0;
      doze_q  <= 1'b0;
      ctl_pre <= '0;
      flag    <= 1'b0;
      mod     <= '0;
      irq     <= 1'b0;
    end else begin
      flag <= flag_n;
      ctl_ie <= ie_n;
      irq  <= ie_n && flag_n;
      if (wr_ctl) begin
        ctl_en  <= wdata[B_EN];
        ctl_rld <= wdata[B_RLD];
        ctl_ovw <= wdata[B_OVW];
        dbg_q   <= wdata[B_DBG];
        doze_q  <= wdata[B_DOZE];
        ctl_pre <= wdata[B_PRE_LSB +: PRE_W];
      end
      if (wr_mod) mod <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!aligned)                         rdata <= '0;
      else if (sel == SEL_W'(REG_CTRL))     rdata <= ctl_img;
      else if (sel == SEL_W'(REG_MOD))      rdata <= mod;
      else if (sel == SEL_W'(REG_CNT))      rdata <= cnt;
      else                                  rdata <= '0;
    end
  end
endmodule

// File: rtl/pit16_prescale.sv
module pit16_prescale #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = 1 << PRE_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // divisor 2^(code+1): low code+1 bits all ones marks terminal count
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i <= int'(code));
    end
  end

  assign tick = run && !clear && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pit16_counter.sv
module pit16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rld,
  input  logic [CNT_W-1:0] mod,
  input  logic             restart,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      if (start) cnt <= start_val;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      if (cnt == '0) cnt <= rld ? mod : '1;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pit16_timer.sv
module pit16_timer #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic             ctl_en, ctl_rld, ctl_ie, ctl_ovw;
  logic [PRE_W-1:0] ctl_pre;
  logic             flag_q;
  logic [CNT_W-1:0] mod_q, cnt_q, start_val;
  logic             restart, start, mod_load;
  logic             tick, expire;

  pit16_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_q), .expire(expire),
    .ctl_en(ctl_en), .ctl_rld(ctl_rld), .ctl_ie(ctl_ie), .ctl_ovw(ctl_ovw),
    .ctl_pre(ctl_pre), .flag(flag_q), .mod(mod_q),
    .restart(restart), .start(start), .start_val(start_val),
    .mod_load(mod_load), .rdata(rdata), .irq(irq)
  );

  pit16_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_en), .clear(restart),
    .code(ctl_pre), .tick(tick)
  );

  pit16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .rld(ctl_rld), .mod(mod_q),
    .restart(restart), .start(start), .start_val(start_val),
    .load(mod_load), .load_val(wdata), .cnt(cnt_q), .expire(expire)
  );
endmodule

// File: rtl/pit16_checker.sv
module pit16_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              irq,
  input logic              ctl_en,
  input logic              ctl_rld,
  input logic              ctl_ie,
  input logic              ctl_ovw,
  input logic              flag_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              expire
);
  logic wr_ctl, wr_mod, wr_cnt;
  assign wr_ctl = wr_en && (addr == ADDR_W'(0));
  assign wr_mod = wr_en && (addr == ADDR_W'(2));
  assign wr_cnt = wr_en && (addr == ADDR_W'(4));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl_ie && flag_q));

  assert_expire_flag_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  assert_reload_mod_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && ctl_rld && !wr_en) |=> (cnt_q == $past(mod_q)));

  assert_wrap_full_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctl_rld && !wr_en) |=> (cnt_q == '1));

  assert_modwr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_mod && !expire) |=> !flag_q);

  assert_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_mod && ctl_ovw) |=> (cnt_q == $past(wdata)));

  assert_hold_stopped_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !wr_en) |=> $stable(cnt_q));

  assert_cnt_wr_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> ($stable(mod_q) && $stable(ctl_en) && $stable(ctl_rld)));

  assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (expire && wr_ctl && wdata[2]) |=> flag_q);
endmodule

bind pit16_timer pit16_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .ctl_en(ctl_en), .ctl_rld(ctl_rld), .ctl_ie(ctl_ie), .ctl_ovw(ctl_ovw),
  .flag_q(flag_q), .mod_q(mod_q), .cnt_q(cnt_q), .expire(expire)
);

// File: tb/tb_pit16_timer.sv
module tb_pit16_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  pit16_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns the edge index of the write
  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    e = cyc;
  endtask

  // returns data and the edge index at which it was sampled
  task automatic rd(input logic [2:0] a, output logic [15:0] d, output int x);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    x = cyc;
    @(negedge clk);
    d = rdata;
  endtask

  // count t edges after a start load of l with divisor dv
  function automatic logic [15:0] exp_cnt(int t, int dv, int l);
    int k;
    k = t / dv;
    return 16'(l - (k % (l + 1)));
  endfunction

  task automatic wait_to(int target);
    while (cyc < target) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    int e, x, m, e2;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(3'd0, v, x); chk("R1 ctrl", v, 16'h0000);
    rd(3'd2, v, x); chk("R1 mod", v, 16'h0000);
    rd(3'd4, v, x); chk("R1 cnt", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R3/R4 reload counting, divisor 2, modulus 9
    wr(3'd2, 16'd9, e);
    rd(3'd2, v, x); chk("R2 mod readback", v, 16'd9);
    wr(3'd0, 16'h0003, e);
    rd(3'd4, v, x); chk("R3 first count", v, exp_cnt(x-1-e, 2, 9));
    repeat (5) @(posedge clk);
    rd(3'd4, v, x); chk("R3 mid count", v, exp_cnt(x-1-e, 2, 9));
    repeat (17) @(posedge clk);
    rd(3'd4, v, x); chk("R4 after reload", v, exp_cnt(x-1-e, 2, 9));
    rd(3'd0, v, x); chk("R4 flag set", v, 16'h0007);
    chk("R7 irq off with ie clear", {15'd0, irq}, 16'h0000);

    // R10 light write: enable interrupt only
    wr(3'd0, 16'h000B, m);
    chk("R7 irq on", {15'd0, irq}, 16'h0001);
    rd(3'd4, v, x); chk("R10 phase kept", v, exp_cnt(x-1-e, 2, 9));

    // R11 stop, R6 flag acknowledge
    wr(3'd0, 16'h000A, m);
    rd(3'd4, v, x);
    repeat (6) @(posedge clk);
    rd(3'd4, v2, x); chk("R11 hold when stopped", v2, v);
    rd(3'd0, v, x); chk("R6 flag kept", v, 16'h000E);
    wr(3'd0, 16'h000A, m);
    rd(3'd0, v, x); chk("R6 write 0 leaves flag", v, 16'h000E);
    wr(3'd0, 16'h000E, m);
    rd(3'd0, v, x); chk("R6 write 1 clears flag", v, 16'h000A);
    chk("R7 irq off after ack", {15'd0, irq}, 16'h0000);

    // R5 wrap mode, divisor 4
    wr(3'd2, 16'd5, m);
    wr(3'd0, 16'h0101, e);
    repeat (13) @(posedge clk);
    rd(3'd4, v, x); chk("R5 wrap start", v, exp_cnt(x-1-e, 4, 65535));

    // R9 overwrite with reload clear
    wr(3'd0, 16'h0111, e2);
    repeat (3) @(posedge clk);
    wr(3'd2, 16'h1234, m);
    repeat (7) @(posedge clk);
    rd(3'd4, v, x);
    chk("R9 overwrite load", v, 16'(16'h1234 - ((x-1-e2)/4 - (m-e2)/4)));

    // R9 no overwrite with reload set
    wr(3'd0, 16'h0003, e);
    wr(3'd2, 16'd2, m);
    rd(3'd4, v, x); chk("R9 count untouched", v, exp_cnt(x-1-e, 2, 16'h1234));

    // R8 modulus write clears flag
    wr(3'd0, 16'h0002, m);
    wr(3'd0, 16'h0003, e);
    repeat (14) @(posedge clk);
    wr(3'd0, 16'h0002, m);
    rd(3'd0, v, x); chk("R8 flag before", v, 16'h0006);
    wr(3'd2, 16'd7, m);
    rd(3'd0, v, x); chk("R8 flag cleared", v, 16'h0002);

    // R12 writes to count ignored
    rd(3'd4, v, x);
    wr(3'd4, 16'hABCD, m);
    rd(3'd4, v2, x); chk("R12 count unchanged", v2, v);
    rd(3'd2, v2, x); chk("R12 mod unchanged", v2, 16'd7);
    rd(3'd0, v2, x); chk("R12 ctrl unchanged", v2, 16'h0002);

    // R13 expiry collides with acknowledge
    wr(3'd2, 16'd3, m);
    wr(3'd0, 16'h000B, e);
    wait_to(e + 7);
    wr(3'd0, 16'h000F, m);
    chk("R13 edge alignment", 16'(m - e), 16'd8);
    chk("R13 irq stays", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h000F, m);
    chk("R13 later ack clears", {15'd0, irq}, 16'h0000);
    rd(3'd0, v, x); chk("R13 flag read", v, 16'h000B);
    rd(3'd4, v, x); chk("R10 phase after acks", v, exp_cnt(x-1-e, 2, 3));

    // R2 layout and unmapped offsets
    wr(3'd0, 16'h0560, m);
    rd(3'd0, v, x); chk("R2 ctrl layout", v, 16'h0560);
    rd(3'd6, v, x); chk("R2 unmapped", v, 16'h0000);
    rd(3'd1, v, x); chk("R2 misaligned", v, 16'h0000);

    // R3 random prescaler, modulus and reload
    for (int i = 0; i < 20; i++) begin
      int code, md, rl, dly;
      code = int'($urandom % 4);
      md   = int'($urandom % 12);
      rl   = int'($urandom % 2);
      dly  = int'($urandom % 60);
      wr(3'd0, 16'h0000, m);
      wr(3'd2, 16'(md), m);
      wr(3'd0, 16'((code << 8) | (rl << 1) | 1), e);
      repeat (dly) @(posedge clk);
      rd(3'd4, v, x);
      chk("R3 random count", v,
          exp_cnt(x-1-e, 2 << code, (rl != 0) ? md : 65535));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule